// File: doc/BRIEF.md
# TDM PCM Conference Mixer

The mixer sits on a time-division-multiplexed stream of 8-bit mu-law companded samples, one slot per clock with its slot index. A member mask, captured at the frame-start strobe, says which slots take part in the conference. Slots outside the mask are forwarded untouched. Each member sample is expanded to a 14-bit signed linear value, and the two loudest members of the frame are tracked by absolute value.

During the following frame, every member slot is overwritten with a mix built from that pair only. A member that was one of the pair hears the other talker alone. Every other member hears the saturated sum of both talkers. The mix is compressed back to mu-law. Adding only two voices keeps the level constant and avoids the noise build-up of an all-member sum.

Top module: `conf_mixer`

## Requirements
- R1: Under reset out_valid_o is 0 and pcm_o is 8'hFF. Until the first accepted frame-start strobe no slot is a member, so every sample passes through unchanged.
- R2: out_valid_o and out_slot_o repeat valid_i and slot_i one clock later, and the output sample belongs to that same slot.
- R3: A valid slot whose mask bit is 0 appears on pcm_o unchanged.
- R4: A code is expanded by inverting it bitwise and reading bit 7 as the sign (1 = negative), bits 6:4 as exponent e and bits 3:0 as mantissa m. The magnitude is ((2m+33) << e) - 33.
- R5: Compression clips the magnitude to 8158, adds 33, and takes e as the highest set bit among bits 12:6 minus 5 (0 if none). The mantissa is bits e+4 down to e+1. The result is inverted. Linear zero gives 8'hFF, and expanding then compressing any code other than 8'h7F returns it unchanged.
- R6: Loudness is the absolute linear value. Of the member samples in a frame, the two loudest form the pair, and equal loudness goes to the lower slot index.
- R7: The pair chosen in frame N is used for every member slot of frame N+1, starting with the slot that carries the frame-start strobe.
- R8: A member outside the pair receives the compressed sum of both pair values.
- R9: A member that is in the pair receives the other pair value alone.
- R10: The sum is saturated to the range -8192 to 8191 before compression.
- R11: With fewer than two members in a frame, each missing talker counts as zero.
- R12: member_mask_i is sampled only with a valid frame-start strobe. Changes later in the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Marks the first slot of a frame (qualified by valid_i) |
| valid_i | input | 1 | A slot sample is present |
| slot_i | input | SLOT_W | Slot index of the sample |
| pcm_i | input | 8 | Companded input sample |
| member_mask_i | input | NUM_SLOTS | Conference membership, one bit per slot |
| out_valid_o | output | 1 | Output sample present |
| out_slot_o | output | SLOT_W | Slot index of the output sample |
| pcm_o | output | 8 | Companded output sample |

## Verification
The bench builds the mixer with NUM_SLOTS = 8, so a frame lasts eight cycles. This makes it cheap to run one frame for every one of the 256 codes, which checks the expand and compress round trip through a pair member on every code value. The short frame also allows several hundred pseudo-random frames with changing masks, compared against an arithmetic model of the pair selection and mix. Directed frames cover loudness ties, saturation at both rails, frames with one or no members, and a mask that changes in the middle of a frame.

// File: rtl/conf_mix_pkg.sv
package conf_mix_pkg;
  localparam int LIN_W   = 14;
  localparam int PCM_W   = 8;
  localparam int SLOT_FW = 8;
  localparam logic [LIN_W-1:0] MU_BIAS = 14'd33;
  localparam logic [LIN_W-1:0] MU_CLIP = 14'd8158;

  typedef struct packed {
    logic               vld;
    logic [SLOT_FW-1:0] slot;
    logic [LIN_W-1:0]   lin;
    logic [LIN_W-1:0]   mag;
  } talker_t;

  // x displaces y: strictly louder, or equally loud from a lower slot
  function automatic logic louder(talker_t x, talker_t y);
    return !y.vld || (x.mag > y.mag) || (x.mag == y.mag && x.slot < y.slot);
  endfunction
endpackage

// File: rtl/mulaw_expand.sv
module mulaw_expand import conf_mix_pkg::*; (
  input  logic [PCM_W-1:0] code_i,
  output logic [LIN_W-1:0] lin_o,
  output logic [LIN_W-1:0] mag_o
);
  logic [PCM_W-1:0] inv;
  logic [LIN_W-1:0] base, scaled;

  assign inv    = ~code_i;
  assign base   = {{(LIN_W-5){1'b0}}, inv[3:0], 1'b0} + MU_BIAS;
  assign scaled = base << inv[6:4];
  assign mag_o  = scaled - MU_BIAS;
  assign lin_o  = inv[7] ? (LIN_W'(0) - mag_o) : mag_o;
endmodule

// File: rtl/mulaw_compress.sv
module mulaw_compress import conf_mix_pkg::*; (
  input  logic [LIN_W-1:0] lin_i,
  output logic [PCM_W-1:0] code_o
);
  logic [LIN_W-1:0] abs_v, clip_v, biased, shifted;
  logic [2:0]       seg;
  logic             unused_bits;

  assign abs_v  = lin_i[LIN_W-1] ? (LIN_W'(0) - lin_i) : lin_i;
  assign clip_v = (abs_v > MU_CLIP) ? MU_CLIP : abs_v;
  assign biased = clip_v + MU_BIAS;

  always_comb begin
    seg = '0;
    for (int i = 1; i < 8; i++) begin
      if (biased[i+5]) seg = 3'(i);
    end
  end

  assign shifted     = biased >> ({1'b0, seg} + 4'd1);
  assign code_o      = ~{lin_i[LIN_W-1], seg, shifted[3:0]};
  assign unused_bits = ^{shifted[LIN_W-1:4], biased[LIN_W-1]};
endmodule

// File: rtl/talker_tracker.sv
module talker_tracker import conf_mix_pkg::*; (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    restart_i,
  input  logic    cand_vld_i,
  input  talker_t cand_i,
  output talker_t top_a_o,
  output talker_t top_b_o
);
  talker_t a_q, b_q, base_a, base_b, a_d, b_d;

  always_comb begin
    base_a = restart_i ? '0 : a_q;
    base_b = restart_i ? '0 : b_q;
    a_d    = base_a;
    b_d    = base_b;
    if (cand_vld_i) begin
      if (louder(cand_i, base_a)) begin
        b_d = base_a;
        a_d = cand_i;
      end else if (louder(cand_i, base_b)) begin
        b_d = cand_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign top_a_o = a_q;
  assign top_b_o = b_q;
endmodule

// File: rtl/mix_select.sv
module mix_select import conf_mix_pkg::*; (
  input  talker_t            a_i,
  input  talker_t            b_i,
  input  logic [SLOT_FW-1:0] slot_i,
  output logic [LIN_W-1:0]   lin_o
);
  logic [LIN_W-1:0]    la, lb, sat_v;
  logic signed [LIN_W:0] sum;

  assign la  = a_i.vld ? a_i.lin : '0;
  assign lb  = b_i.vld ? b_i.lin : '0;
  assign sum = $signed({la[LIN_W-1], la}) + $signed({lb[LIN_W-1], lb});

  always_comb begin
    if (sum[LIN_W] != sum[LIN_W-1])
      sat_v = sum[LIN_W] ? {1'b1, {(LIN_W-1){1'b0}}} : {1'b0, {(LIN_W-1){1'b1}}};
    else
      sat_v = sum[LIN_W-1:0];
  end

  always_comb begin
    if (a_i.vld && slot_i == a_i.slot)      lin_o = lb;
    else if (b_i.vld && slot_i == b_i.slot) lin_o = la;
    else                                    lin_o = sat_v;
  end
endmodule

// File: rtl/conf_mixer.sv
module conf_mixer import conf_mix_pkg::*; #(
  parameter  int NUM_SLOTS = 32,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_start_i,
  input  logic                 valid_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [PCM_W-1:0]     pcm_i,
  input  logic [NUM_SLOTS-1:0] member_mask_i,
  output logic                 out_valid_o,
  output logic [SLOT_W-1:0]    out_slot_o,
  output logic [PCM_W-1:0]     pcm_o
);
  logic                 restart, member;
  logic [NUM_SLOTS-1:0] mask_q, mask_eff;
  logic [LIN_W-1:0]     cand_lin, cand_mag, mix_lin;
  logic [PCM_W-1:0]     mix_code;
  talker_t              cand, run_a, run_b, pair_a_q, pair_b_q, act_a, act_b;

  assign restart  = frame_start_i & valid_i;
  assign mask_eff = restart ? member_mask_i : mask_q;
  assign member   = valid_i & mask_eff[slot_i];

  mulaw_expand u_exp (.code_i(pcm_i), .lin_o(cand_lin), .mag_o(cand_mag));

  assign cand = '{vld: member, slot: SLOT_FW'(slot_i), lin: cand_lin, mag: cand_mag};

  talker_tracker u_trk (
    .clk_i, .rst_ni,
    .restart_i(restart), .cand_vld_i(member), .cand_i(cand),
    .top_a_o(run_a), .top_b_o(run_b)
  );

  // completed frame's pair takes effect on the strobe slot itself
  assign act_a = restart ? run_a : pair_a_q;
  assign act_b = restart ? run_b : pair_b_q;

  mix_select u_mix (.a_i(act_a), .b_i(act_b), .slot_i(SLOT_FW'(slot_i)), .lin_o(mix_lin));

  mulaw_compress u_cmp (.lin_i(mix_lin), .code_o(mix_code));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      pair_a_q <= '0;
      pair_b_q <= '0;
    end else if (restart) begin
      mask_q   <= member_mask_i;
      pair_a_q <= run_a;
      pair_b_q <= run_b;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_slot_o  <= '0;
      pcm_o       <= 8'hFF;
    end else begin
      out_valid_o <= valid_i;
      if (valid_i) begin
        out_slot_o <= slot_i;
        pcm_o      <= member ? mix_code : pcm_i;
      end
    end
  end
endmodule

// File: rtl/conf_mixer_chk.sv
module conf_mixer_chk import conf_mix_pkg::*; #(
  parameter  int NUM_SLOTS = 32,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 frame_start_i,
  input logic                 valid_i,
  input logic [SLOT_W-1:0]    slot_i,
  input logic [PCM_W-1:0]     pcm_i,
  input logic                 out_valid_o,
  input logic [SLOT_W-1:0]    out_slot_o,
  input logic [PCM_W-1:0]     pcm_o,
  input logic [NUM_SLOTS-1:0] mask_q,
  input talker_t              pair_a_q,
  input talker_t              pair_b_q
);
  logic seen_fs;
  logic mid_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_fs <= 1'b0;
    else if (frame_start_i && valid_i) seen_fs <= 1'b1;
  end

  assign mid_frame = valid_i && !frame_start_i;

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> out_valid_o);
  assert_idle_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !out_valid_o);
  assert_slot_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> out_slot_o == $past(slot_i));
  assert_pre_frame_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_frame && !seen_fs) |=> pcm_o == $past(pcm_i));
  assert_nonmember_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_frame && !mask_q[slot_i]) |=> pcm_o == $past(pcm_i));
  assert_pair_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_b_q.vld |-> (pair_a_q.vld && pair_a_q.mag >= pair_b_q.mag));
  assert_lone_talker_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_frame && mask_q[slot_i] && pair_a_q.vld && !pair_b_q.vld
     && SLOT_FW'(slot_i) == pair_a_q.slot) |=> pcm_o == 8'hFF);
  assert_no_talker_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_frame && mask_q[slot_i] && !pair_a_q.vld) |=> pcm_o == 8'hFF);
endmodule

bind conf_mixer conf_mixer_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (.*);

// File: tb/conf_mixer_tb.sv
module conf_mixer_tb_top;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fs = 1'b0, vld = 1'b0;
  logic [2:0]    slot = '0;
  logic [7:0]    pcm = '0;
  logic [NS-1:0] mask = '0;
  logic          o_vld;
  logic [2:0]    o_slot;
  logic [7:0]    o_pcm;

  int checks = 0, errors = 0;

  conf_mixer #(.NUM_SLOTS(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .valid_i(vld),
    .slot_i(slot), .pcm_i(pcm), .member_mask_i(mask),
    .out_valid_o(o_vld), .out_slot_o(o_slot), .pcm_o(o_pcm)
  );

  always #10 clk = ~clk;

  // ---------------- reference arithmetic ----------------
  function automatic int exp_f(logic [7:0] code);
    logic [7:0] c = ~code;
    int e = int'(c[6:4]);
    int m = int'(c[3:0]);
    int mag = (2*m + 33) * (1 << e) - 33;
    return c[7] ? -mag : mag;
  endfunction

  function automatic logic [7:0] cmp_f(int v);
    logic s = (v < 0);
    int a = s ? -v : v;
    int seg = 0;
    int man;
    if (a > 8158) a = 8158;
    a = a + 33;
    while (seg < 7 && a >= (64 << seg)) seg++;
    man = (a >> (seg + 1)) % 16;
    return ~{s, 3'(seg), 4'(man)};
  endfunction

  function automatic int sat_f(int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  // ---------------- model state ----------------
  bit seen = 0;
  logic [NS-1:0] mcur = '0;
  bit ra_v, rb_v, pa_v, pb_v;
  int ra_s, rb_s, pa_s, pb_s, ra_l, rb_l, pa_l, pb_l;

  function automatic bit beats(int m, int s, bit yv, int ym, int ys);
    return !yv || m > ym || (m == ym && s < ys);
  endfunction

  // ---------------- pending output ----------------
  bit pend = 0, pend_v;
  int pend_slot, pend_want;
  logic [7:0] pend_code;
  string pend_tag;

  task automatic chk(bit ok, string tag, string what, int got, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, expv);
    end
  endtask

  task automatic check_pending();
    if (!pend) return;
    chk(o_vld === pend_v, "R2", "out_valid", int'(o_vld), int'(pend_v));
    if (pend_v) begin
      chk(int'(o_slot) == pend_slot, "R2", "out_slot", int'(o_slot), pend_slot);
      chk(o_pcm === pend_code, pend_tag, "pcm", int'(o_pcm), int'(pend_code));
      if (pend_want >= 0)
        chk(int'(o_pcm) == pend_want, pend_tag, "pcm directed", int'(o_pcm), pend_want);
    end
  endtask

  task automatic drive_slot(bit f, int s, logic [7:0] code, logic [NS-1:0] mdrv, int want, string wtag);
    bit mem;
    int la, lb, sum, l, m;
    @(negedge clk);
    check_pending();
    if (f) begin
      seen = 1;
      pa_v = ra_v; pa_s = ra_s; pa_l = ra_l;
      pb_v = rb_v; pb_s = rb_s; pb_l = rb_l;
      ra_v = 0; rb_v = 0;
      mcur = mdrv;
    end
    mem = mcur[s];
    if (!seen) begin
      pend_code = code; pend_tag = "R1";
    end else if (!mem) begin
      pend_code = code; pend_tag = (wtag != "") ? wtag : "R3";
    end else begin
      la = pa_v ? pa_l : 0;
      lb = pb_v ? pb_l : 0;
      if (pa_v && s == pa_s) begin
        pend_code = cmp_f(lb); pend_tag = pb_v ? "R9" : "R11";
      end else if (pb_v && s == pb_s) begin
        pend_code = cmp_f(la); pend_tag = "R9";
      end else begin
        sum = la + lb;
        pend_code = cmp_f(sat_f(sum));
        if (!pa_v || !pb_v) pend_tag = "R11";
        else if (sum > 8191 || sum < -8192) pend_tag = "R10";
        else pend_tag = "R8";
      end
      if (f) pend_tag = "R7";
      if (wtag != "") pend_tag = wtag;
      l = exp_f(code);
      m = (l < 0) ? -l : l;
      if (beats(m, s, ra_v, (ra_l < 0) ? -ra_l : ra_l, ra_s)) begin
        rb_v = ra_v; rb_s = ra_s; rb_l = ra_l;
        ra_v = 1; ra_s = s; ra_l = l;
      end else if (beats(m, s, rb_v, (rb_l < 0) ? -rb_l : rb_l, rb_s)) begin
        rb_v = 1; rb_s = s; rb_l = l;
      end
    end
    pend = 1; pend_v = 1; pend_slot = s; pend_want = want;
    fs = f; vld = 1; slot = 3'(s); pcm = code; mask = mdrv;
  endtask

  task automatic idle();
    @(negedge clk);
    check_pending();
    fs = 0; vld = 0;
    pend = 1; pend_v = 0;
  endtask

  logic [7:0] fr_code [NS];
  int         fr_want [NS];
  string      fr_tag  [NS];

  task automatic run_frame(logic [NS-1:0] mfs, logic [NS-1:0] mmid);
    for (int s = 0; s < NS; s++)
      drive_slot(s == 0, s, fr_code[s], (s == 0) ? mfs : mmid, fr_want[s], fr_tag[s]);
    for (int s = 0; s < NS; s++) begin
      fr_want[s] = -1; fr_tag[s] = "";
    end
  endtask

  task automatic fill(logic [7:0] v);
    for (int s = 0; s < NS; s++) fr_code[s] = v;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    logic [NS-1:0] mf, mm;
    for (int s = 0; s < NS; s++) begin
      fr_want[s] = -1; fr_tag[s] = "";
    end
    repeat (3) @(negedge clk);
    chk(o_vld === 1'b0, "R1", "reset out_valid", int'(o_vld), 0);
    chk(o_pcm === 8'hFF, "R1", "reset pcm", int'(o_pcm), 255);
    rst_n = 1'b1;
    @(negedge clk);
    chk(o_vld === 1'b0, "R1", "post-reset out_valid", int'(o_vld), 0);

    // R1: no strobe yet, full mask driven, everything passes
    for (int s = 0; s < NS; s++) drive_slot(0, s, 8'(s * 37 + 5), '1, -1, "");
    idle(); idle();

    // R4 R5: every code through a pair member
    for (int k = 0; k <= 256; k++) begin
      fill(8'h5A);
      fr_code[0] = 8'(k);
      fr_code[1] = 8'hFF;
      if (k > 0) begin
        fr_want[1] = (k - 1 == 8'h7F) ? 8'hFF : (k - 1);
        fr_tag[1]  = "R5";
      end
      run_frame(8'b0000_0011, 8'b0000_0011);
    end

    // R4: 33 + 99 = 132 -> 0xDB on the non-pair member
    fill(8'hC3);
    fr_code[0] = 8'hEF; fr_code[1] = 8'hDF; fr_code[2] = 8'hFF;
    run_frame(8'b0000_0111, 8'b0000_0111);
    fr_code[0] = 8'hEF; fr_code[1] = 8'hDF; fr_code[2] = 8'hFF;
    fr_want[2] = 8'hDB; fr_tag[2] = "R4";
    run_frame(8'b0000_0111, 8'b0000_0111);

    // R6: three equal magnitudes, lower slots win
    fill(8'h33);
    fr_code[2] = 8'hA5; fr_code[5] = 8'h25; fr_code[6] = 8'hA5;
    run_frame(8'b0110_0100, 8'b0110_0100);
    fr_code[2] = 8'hA5; fr_code[5] = 8'h25; fr_code[6] = 8'hA5;
    fr_want[6] = 8'hFF; fr_tag[6] = "R6";
    fr_want[2] = 8'h25; fr_tag[2] = "R6";
    fr_want[5] = 8'hA5; fr_tag[5] = "R6";
    run_frame(8'b0110_0100, 8'b0110_0100);

    // R10: saturation at both rails
    fill(8'h71);
    fr_code[0] = 8'h80; fr_code[1] = 8'h80; fr_code[3] = 8'hFF;
    run_frame(8'b0000_1011, 8'b0000_1011);
    fill(8'h71);
    fr_code[0] = 8'h00; fr_code[1] = 8'h00; fr_code[3] = 8'hFF;
    fr_want[3] = 8'h80; fr_tag[3] = "R10";
    run_frame(8'b0000_1011, 8'b0000_1011);
    fill(8'h71);
    fr_want[3] = 8'h00; fr_tag[3] = "R10";
    run_frame(8'b0000_1011, 8'b0000_1011);

    // R11: single member, then no member
    fill(8'h90);
    run_frame(8'b0001_0000, 8'b0001_0000);
    fr_want[4] = 8'hFF; fr_tag[4] = "R11";
    run_frame(8'b0001_0000, 8'b0001_0000);
    run_frame(8'b0000_0000, 8'b0000_0000);
    fill(8'hB7);
    for (int s = 0; s < NS; s++) begin
      fr_want[s] = 8'hFF; fr_tag[s] = "R11";
    end
    run_frame(8'hFF, 8'hFF);

    // R12: mask raised mid-frame must not pull slot 5 in
    fill(8'h4E);
    fr_code[5] = 8'h9D;
    fr_want[5] = 8'h9D; fr_tag[5] = "R12";
    run_frame(8'b0000_0011, 8'hFF);

    // R6 R7 R8 R9 R10: pseudo-random frames
    for (int f = 0; f < 300; f++) begin
      for (int s = 0; s < NS; s++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        fr_code[s] = lfsr[15:8];
      end
      mf = lfsr[NS+2:3];
      mm = (f % 3 == 0) ? ~mf : mf;
      run_frame(mf, mm);
      if (f % 7 == 0) idle();
    end

    idle(); idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule